// File: doc/BRIEF.md
# ADC Result Output Port

This block takes each 16-bit result from a converter core and hands it to a host. The core supplies a conversion-done strobe with its result word, and a conversion-start strobe. Static configuration inputs choose the port. In parallel mode the formatted result sits on a 16-bit bus, and the host can read that bus as two byte lanes in either order. In serial mode one shift register sends the word MSB first with a data line, a clock and a frame sync.

In serial mode the block can act as clock master or clock slave. As master it makes its own serial clock from the system clock. The rate is set by a 2-bit divider code, and the host chooses whether a word goes out as soon as its conversion completes or only when the next conversion starts. As slave it shifts on an external clock that is qualified by an active-low chip select. A serial input is shifted in behind the word, so several devices can be chained onto one data line. The output code format and the polarities of the clock and the sync are selectable. All slave inputs are resynchronised to the system clock.

Top module: `adc_result_port`

## Requirements
- R1: With ser_sel=0, par_oe is 1 and par_data takes the formatted result on the clock edge that samples conv_done. par_data holds while no strobe arrives, and sync_o stays at its inactive level. With ser_sel=1, par_oe is 0.
- R2: With fmt_bin=1 the result is passed unchanged (straight binary). With fmt_bin=0 bit 15 is inverted (twos complement). The format applies to both the parallel path and the serial path.
- R3: With byte_swap=0, par_data[7:0] carries the low byte and par_data[15:8] the high byte. With byte_swap=1 the two bytes trade places.
- R4: In master mode (ser_sel=1, slave_sel=0, rd_during=0), a conv_done strobe starts a transfer of the formatted word, MSB first. sdout is stable at every rising edge of the non-inverted serial clock, and a word has exactly 16 such edges.
- R5: In master mode with rd_during=0, divider code d gives a serial clock period of 2^(d+1) system clocks. With rd_during=1 the period is 2 clocks whatever the code.
- R6: sync_o is active for exactly 16 bit periods per master word (32·2^d clocks). In slave mode it is active from chip select until the 16th active clock edge. With sync_low=0 the active level is high; with sync_low=1 it is low.
- R7: sclk_inv=1 inverts the serial clock in both master and slave mode. When no master transfer is running, sclk_o rests at the level of sclk_inv.
- R8: A conv_done that arrives during a master transfer with rd_during=0 is held. Its word is sent right after the current word ends, with a one-clock gap in sync, and nothing is lost.
- R9: In master mode with rd_during=1, conv_done only stores the result. A conv_start strobe sends the stored result.
- R10: In slave mode, a falling cs_n loads the stored result and sdout shows its MSB. Each rising edge of (sclk_i XOR sclk_inv) with cs_n low moves the next bit onto sdout. Clock edges while cs_n is high leave sdout unchanged.
- R11: In slave mode, the sdin level sampled at each active clock edge appears on sdout 16 active edges after it was taken, which allows daisy-chaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: conversion complete, conv_result valid |
| conv_start | input | 1 | One-cycle strobe: a new conversion begins |
| conv_result | input | 16 | Result word from the converter core, straight binary |
| ser_sel | input | 1 | 0 selects the parallel port, 1 the serial port |
| fmt_bin | input | 1 | 1 straight binary, 0 twos complement |
| byte_swap | input | 1 | 1 exchanges the bytes on par_data |
| slave_sel | input | 1 | 0 internal serial clock, 1 external serial clock |
| sync_low | input | 1 | 1 makes sync_o active low |
| sclk_inv | input | 1 | 1 inverts the serial clock |
| rd_during | input | 1 | Master: 1 sends the previous word at conversion start |
| sclk_div | input | 2 | Master clock divider code |
| cs_n | input | 1 | Slave chip select, active low |
| sclk_i | input | 1 | External serial clock in slave mode |
| sdin | input | 1 | Daisy-chain serial input in slave mode |
| par_data | output | 16 | Parallel result bus |
| par_oe | output | 1 | Enable for the parallel pad drivers |
| sdout | output | 1 | Serial data output |
| sclk_o | output | 1 | Serial clock output in master mode |
| sync_o | output | 1 | Serial frame sync |

## Verification
A bit counter or a divider that is wrong changes the sync width or the spacing of clock edges within the first word. The bench measures both for every divider code. A wrong load or a wrong format shows in the received word at the first strobe. A held word that is dropped shows as a missing second frame. In slave mode the daisy-chain ordering is only visible after 16 edges, so the bench clocks 32 edges per frame and checks each bit as it appears.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_DIV_W  = 2;
  localparam int DEF_SYNC   = 2;

  // What the master shifter loads when it is idle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NEW  = 2'd1,
    SRC_PEND = 2'd2,
    SRC_HELD = 2'd3
  } load_src_e;
endpackage

// File: rtl/adc_port_capture.sv
module adc_port_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  input  logic         fmt_bin,
  input  logic         byte_swap,
  input  logic         ser_sel,
  output logic [W-1:0] fmt_word,
  output logic [W-1:0] result_word,
  output logic [W-1:0] par_data,
  output logic         par_oe
);
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;

  always_comb begin
    fmt_word = conv_result;
    if (!fmt_bin) fmt_word[W-1] = ~conv_result[W-1];
    swapped = byte_swap ? {fmt_word[HALF-1:0], fmt_word[W-1:HALF]} : fmt_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_word <= '0;
      par_data    <= '0;
      par_oe      <= 1'b0;
    end else begin
      par_oe <= ~ser_sel;
      if (conv_done) begin
        result_word <= fmt_word;
        par_data    <= swapped;
      end
    end
  end

  // R1: the bus only moves on a strobe
  p_par_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(par_data));
endmodule

// File: rtl/adc_port_master.sv
module adc_port_master
  import adc_port_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rd_during,
  input  logic [DIV_W-1:0] div,
  input  logic             conv_done,
  input  logic             conv_start,
  input  logic [W-1:0]     fmt_word,
  input  logic [W-1:0]     result_word,
  output logic             sdout,
  output logic             sclk,
  output logic             sync
);
  localparam int HC_W = (1 << DIV_W) - 1;
  localparam int BC_W = $clog2(W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(W - 1);

  logic [W-1:0]    shreg, pend_word;
  logic            pend, busy, phase;
  logic [HC_W-1:0] hc, half_lim;
  logic [BC_W-1:0] bitcnt;
  load_src_e       src;

  always_comb begin
    half_lim = rd_during ? '0 : HC_W'((32'd1 << div) - 32'd1);
    if (busy)                 src = SRC_NONE;
    else if (rd_during)       src = conv_start ? SRC_HELD : SRC_NONE;
    else if (pend)            src = SRC_PEND;
    else if (conv_done)       src = SRC_NEW;
    else                      src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy      <= 1'b0;
      phase     <= 1'b0;
      hc        <= '0;
      bitcnt    <= '0;
      pend      <= 1'b0;
      shreg     <= '0;
      pend_word <= '0;
    end else begin
      case (src)
        SRC_NEW:  shreg <= fmt_word;
        SRC_PEND: shreg <= pend_word;
        SRC_HELD: shreg <= result_word;
        default:  ;
      endcase
      if (src != SRC_NONE) begin
        busy   <= 1'b1;
        phase  <= 1'b0;
        hc     <= '0;
        bitcnt <= '0;
      end else if (busy) begin
        if (hc == half_lim) begin
          hc    <= '0;
          phase <= ~phase;
          if (phase) begin
            shreg  <= {shreg[W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) busy <= 1'b0;
          end
        end else begin
          hc <= hc + 1'b1;
        end
      end
      if (!rd_during && conv_done && (busy || src == SRC_PEND)) begin
        pend      <= 1'b1;
        pend_word <= fmt_word;
      end else if (src == SRC_PEND || rd_during) begin
        pend <= 1'b0;
      end
    end
  end

  assign sdout = shreg[W-1];
  assign sclk  = phase;
  assign sync  = busy;

  // R7: clock rests low between words
  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !phase);
  // R8: a strobe during a transfer is held
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !rd_during && busy && conv_done) |=> pend);
  // R6: a word ends after exactly W bit periods
  p_word_len_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(en)) |-> bitcnt == '0);
  // R5: half-period counter stays inside the selected divider
  p_div_range_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $stable(rd_during) && $stable(div)) |-> hc <= half_lim);
endmodule

// File: rtl/adc_port_slave.sv
module adc_port_slave #(
  parameter int W   = 16,
  parameter int STG = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sclk_inv,
  input  logic         cs_n,
  input  logic         sclk_i,
  input  logic         sdin,
  input  logic [W-1:0] result_word,
  output logic         sdout,
  output logic         sync
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [STG:0]     clk_pipe, cs_pipe;
  logic [STG-1:0]   din_pipe;
  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;
  logic             act_edge, cs_fall, cs_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      cs_pipe  <= '1;
      din_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[STG-1:0], sclk_i ^ sclk_inv};
      cs_pipe  <= {cs_pipe[STG-1:0], cs_n};
      din_pipe <= {din_pipe[STG-2:0], sdin};
    end
  end

  assign act_edge = clk_pipe[STG-1] & ~clk_pipe[STG];
  assign cs_fall  = ~cs_pipe[STG-1] & cs_pipe[STG];
  assign cs_on    = ~cs_pipe[STG-1];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      shreg <= result_word;
      cnt   <= '0;
    end else if (!cs_on) begin
      cnt <= '0;
    end else if (act_edge) begin
      shreg <= {shreg[W-2:0], din_pipe[STG-1]};
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end

  assign sdout = shreg[W-1];
  assign sync  = cs_on && (cnt != FULL);

  // R10: nothing shifts while chip select is inactive
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (rst || !en)
    !cs_on |=> shreg == $past(shreg));
  // R11: edge count saturates at one word
  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_port_pkg::*;
#(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int DIV_W    = DEF_DIV_W,
  parameter int SYNC_STG = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic              conv_start,
  input  logic [WORD_W-1:0] conv_result,
  input  logic              ser_sel,
  input  logic              fmt_bin,
  input  logic              byte_swap,
  input  logic              slave_sel,
  input  logic              sync_low,
  input  logic              sclk_inv,
  input  logic              rd_during,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic              cs_n,
  input  logic              sclk_i,
  input  logic              sdin,
  output logic [WORD_W-1:0] par_data,
  output logic              par_oe,
  output logic              sdout,
  output logic              sclk_o,
  output logic              sync_o
);
  logic [WORD_W-1:0] fmt_word, result_word;
  logic m_en, s_en;
  logic m_sdout, m_sclk, m_sync;
  logic s_sdout, s_sync;
  logic ser_sdout, ser_sync;

  assign m_en = ser_sel & ~slave_sel;
  assign s_en = ser_sel & slave_sel;

  adc_port_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
    .fmt_bin(fmt_bin), .byte_swap(byte_swap), .ser_sel(ser_sel),
    .fmt_word(fmt_word), .result_word(result_word),
    .par_data(par_data), .par_oe(par_oe)
  );

  adc_port_master #(.W(WORD_W), .DIV_W(DIV_W)) u_mst (
    .clk(clk), .rst(rst), .en(m_en), .rd_during(rd_during), .div(sclk_div),
    .conv_done(conv_done), .conv_start(conv_start),
    .fmt_word(fmt_word), .result_word(result_word),
    .sdout(m_sdout), .sclk(m_sclk), .sync(m_sync)
  );

  adc_port_slave #(.W(WORD_W), .STG(SYNC_STG)) u_slv (
    .clk(clk), .rst(rst), .en(s_en), .sclk_inv(sclk_inv),
    .cs_n(cs_n), .sclk_i(sclk_i), .sdin(sdin), .result_word(result_word),
    .sdout(s_sdout), .sync(s_sync)
  );

  always_comb begin
    ser_sdout = 1'b0;
    ser_sync  = 1'b0;
    if (s_en) begin
      ser_sdout = s_sdout;
      ser_sync  = s_sync;
    end else if (m_en) begin
      ser_sdout = m_sdout;
      ser_sync  = m_sync;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdout  <= 1'b0;
      sclk_o <= sclk_inv;
      sync_o <= sync_low;
    end else begin
      sdout  <= ser_sdout;
      sclk_o <= (m_en & m_sclk) ^ sclk_inv;
      sync_o <= ser_sync ^ sync_low;
    end
  end

  // R1: parallel mode never frames a serial word
  p_sync_par_r1: assert property (@(posedge clk) disable iff (rst)
    (!ser_sel && $past(!ser_sel) && $stable(sync_low)) |-> sync_o == sync_low);
  // R7: serial clock output is idle outside master mode
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(m_en) && $stable(sclk_inv)) |-> sclk_o == sclk_inv);
endmodule

// File: tb/sim_adc_result_port.sv
module sim_adc_result_port;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         conv_done = 0, conv_start = 0;
  logic [W-1:0] conv_result = '0;
  logic ser_sel = 0, fmt_bin = 1, byte_swap = 0, slave_sel = 0;
  logic sync_low = 0, sclk_inv = 0, rd_during = 0;
  logic [1:0] sclk_div = 0;
  logic cs_n = 1, sclk_i = 0, sdin = 0;
  logic [W-1:0] par_data;
  logic par_oe, sdout, sclk_o, sync_o;

  int errors = 0;
  int checks = 0;

  adc_result_port u0 (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_start(conv_start),
    .conv_result(conv_result), .ser_sel(ser_sel), .fmt_bin(fmt_bin),
    .byte_swap(byte_swap), .slave_sel(slave_sel), .sync_low(sync_low),
    .sclk_inv(sclk_inv), .rd_during(rd_during), .sclk_div(sclk_div),
    .cs_n(cs_n), .sclk_i(sclk_i), .sdin(sdin), .par_data(par_data),
    .par_oe(par_oe), .sdout(sdout), .sclk_o(sclk_o), .sync_o(sync_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] efmt(input logic [W-1:0] d, input logic bin);
    return bin ? d : {~d[W-1], d[W-2:0]};
  endfunction

  function automatic logic [W-1:0] epar(input logic [W-1:0] d, input logic bin, input logic sw);
    logic [W-1:0] f;
    f = efmt(d, bin);
    return sw ? {f[7:0], f[15:8]} : f;
  endfunction

  task automatic pulse_done(input logic [W-1:0] d);
    @(negedge clk);
    conv_result = d;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  // Receives one master word at negedges
  task automatic rx(output logic [W-1:0] word, output int edges, output int pmin,
                    output int pmax, output int slen, output bit idle_ok);
    logic act, prev, cur;
    int t, last, guard;
    act = ~sync_low;
    word = '0; edges = 0; pmin = 100000; pmax = 0; slen = 0; idle_ok = 1;
    t = 0; last = -1; guard = 0;
    @(negedge clk);
    while (sync_o != act) begin
      if (sclk_o != sclk_inv) idle_ok = 0;
      @(negedge clk);
      guard++;
      if (guard > 5000) return;
    end
    prev = sclk_o ^ sclk_inv;
    while (sync_o == act) begin
      slen++;
      t++;
      cur = sclk_o ^ sclk_inv;
      if (cur && !prev) begin
        word = {word[W-2:0], sdout};
        edges++;
        if (last >= 0) begin
          if (t - last < pmin) pmin = t - last;
          if (t - last > pmax) pmax = t - last;
        end
        last = t;
      end
      prev = cur;
      @(negedge clk);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    report();
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, w1, w2, f, s_keep;
    int edges, pmin, pmax, slen, act_cnt, e2, pn2, px2, sl2;
    bit idle_ok, ik2;
    logic [31:0] din_bits;
    logic exp_bit;
    void'($urandom(32'd20240611));

    // Reset state
    repeat (3) @(negedge clk);
    check(par_data == '0, "R1 reset par_data", par_data, 0);
    check(par_oe == 1'b0, "R1 reset par_oe", par_oe, 0);
    check(sdout == 1'b0 && sync_o == 1'b0, "R6 reset serial idle", {sdout, sync_o}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(par_oe == 1'b1, "R1 parallel oe", par_oe, 1);

    // Parallel: random words, format and byte order (R1 R2 R3)
    a = 16'h8000; fmt_bin = 0; byte_swap = 0;
    pulse_done(a);
    check(par_data == 16'h0000, "R2 twos complement corner", par_data, 0);
    a = 16'h7FFF; fmt_bin = 0; byte_swap = 1;
    pulse_done(a);
    check(par_data == 16'hFFFF, "R3 swap corner", par_data, 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      fmt_bin = 1'($urandom);
      byte_swap = 1'($urandom);
      a = W'($urandom);
      pulse_done(a);
      f = epar(a, fmt_bin, byte_swap);
      check(par_data == f, "R1 R2 R3 parallel word", par_data, f);
      repeat (2) @(negedge clk);
      check(par_data == f, "R1 bus holds", par_data, f);
    end
    check(sync_o == sync_low, "R1 sync idle in parallel", sync_o, sync_low);
    ser_sel = 1;
    repeat (2) @(negedge clk);
    check(par_oe == 1'b0, "R1 serial mode oe", par_oe, 0);

    // Master read-after-convert, every divider (R4 R5 R6 R7 R2)
    for (int d = 0; d < 4; d++) begin
      slave_sel = 0; rd_during = 0; sclk_div = 2'(d);
      fmt_bin = 1'($urandom); sclk_inv = 1'($urandom); sync_low = 1'($urandom);
      a = W'($urandom);
      repeat (3) @(negedge clk);
      fork
        rx(w1, edges, pmin, pmax, slen, idle_ok);
        pulse_done(a);
      join
      f = efmt(a, fmt_bin);
      check(w1 == f, "R4 master word", w1, f);
      check(edges == 16, "R4 edge count", edges, 16);
      check(pmin == (2 << d) && pmax == (2 << d), "R5 clock period", pmax, 2 << d);
      check(slen == (32 << d), "R6 sync width", slen, 32 << d);
      check(idle_ok, "R7 idle clock level", idle_ok, 1);
    end

    // Read during conversion (R9 R5)
    rd_during = 1; sclk_div = 3; fmt_bin = 0; sclk_inv = 0; sync_low = 0;
    a = 16'h1234;
    repeat (3) @(negedge clk);
    pulse_done(a);
    act_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sync_o) act_cnt++;
    end
    check(act_cnt == 0, "R9 no send on done", act_cnt, 0);
    fork
      rx(w1, edges, pmin, pmax, slen, idle_ok);
      pulse_start();
    join
    check(w1 == efmt(a, 0), "R9 previous word sent", w1, efmt(a, 0));
    check(pmax == 2 && pmin == 2, "R5 divider ignored", pmax, 2);
    check(slen == 32, "R6 sync width fast", slen, 32);

    // Held strobe during transfer (R8)
    rd_during = 0; sclk_div = 1; fmt_bin = 1;
    a = W'($urandom); b = W'($urandom);
    repeat (3) @(negedge clk);
    fork
      begin
        rx(w1, edges, pmin, pmax, slen, idle_ok);
        rx(w2, e2, pn2, px2, sl2, ik2);
      end
      begin
        pulse_done(a);
        repeat (10) @(negedge clk);
        pulse_done(b);
      end
    join
    check(w1 == a, "R8 first word", w1, a);
    check(w2 == b && e2 == 16, "R8 held word", w2, b);

    // Slave with daisy chain (R10 R11 R6 R7)
    slave_sel = 1; sclk_inv = 1'($urandom); sync_low = 1'($urandom); fmt_bin = 1'($urandom);
    sclk_i = sclk_inv; cs_n = 1;
    a = W'($urandom);
    din_bits = $urandom;
    repeat (5) @(negedge clk);
    pulse_done(a);
    f = efmt(a, fmt_bin);
    repeat (3) @(negedge clk);
    cs_n = 0;
    repeat (10) @(negedge clk);
    check(sdout == f[W-1], "R10 msb on select", sdout, f[W-1]);
    check(sync_o == ~sync_low, "R6 slave sync active", sync_o, ~sync_low);
    for (int e = 0; e < 32; e++) begin
      sdin = din_bits[e];
      repeat (5) @(negedge clk);
      sclk_i = ~sclk_inv;
      repeat (10) @(negedge clk);
      sclk_i = sclk_inv;
      repeat (5) @(negedge clk);
      if (e < 15) begin
        exp_bit = f[14-e];
        check(sdout == exp_bit, "R10 slave bit", sdout, exp_bit);
      end else begin
        exp_bit = din_bits[e-15];
        check(sdout == exp_bit, "R11 daisy bit", sdout, exp_bit);
      end
      if (e == 14) check(sync_o == ~sync_low, "R6 slave sync held", sync_o, ~sync_low);
      if (e == 15) check(sync_o == sync_low, "R6 slave sync ends", sync_o, sync_low);
    end
    cs_n = 1;
    repeat (10) @(negedge clk);
    s_keep = {15'd0, sdout};
    for (int e = 0; e < 3; e++) begin
      sdin = ~sdout;
      repeat (5) @(negedge clk);
      sclk_i = ~sclk_inv;
      repeat (10) @(negedge clk);
      sclk_i = sclk_inv;
      repeat (5) @(negedge clk);
    end
    check(sdout == s_keep[0], "R10 edges ignored without select", sdout, s_keep[0]);
    check(sync_o == sync_low, "R6 slave sync idle", sync_o, sync_low);
    check(sclk_o == sclk_inv, "R7 clock out idle in slave", sclk_o, sclk_inv);

    report();
    $finish;
  end
endmodule